// File: doc/BRIEF.md
# Acknowledge-Serviced Watchdog Timer

This block is a watchdog counter that software keeps alive through ordinary bus traffic: each time the serial slave interface acknowledges a transfer, a one-cycle `kick` pulse clears the count. A dummy command serves this purpose as well as a real one. If the count runs for the full timeout without a kick, the block raises a reset request for a fixed pulse length. It then drops the request and starts counting again from zero.

The counter does not run while the supply is below its trip level. Once `supply_ok` rises, the counter waits one pulse length before it starts. Either external reset pin (an active-high level and an active-low level, both already synchronised) forces the block into the same held state. It leaves that state only when the pulse length has elapsed since the assertion and the pin has been released, whichever comes later. The caller combines `rst_req` with the supply-controller and pin drivers.

Top module: `ack_watchdog`

## Requirements
- R1: While `supply_ok` is low, `rst_req` and `timing_out` are 0, and a kick has no effect.
- R2: After `supply_ok` rises, the counter stays held for PULSE_CYC cycles and ignores kicks. With no later kick, `rst_req` first rises at the clock edge PULSE_CYC+TIMEOUT_CYC after the release.
- R3: While counting, TIMEOUT_CYC clock edges without a kick raise `rst_req` at the last of those edges.
- R4: A kick while counting returns the count to zero, so the next request comes TIMEOUT_CYC edges after the kick.
- R5: A kick in the same cycle as the terminal count wins: no request is raised and the count restarts from zero.
- R6: A timeout-driven `rst_req` stays high for exactly PULSE_CYC cycles when no external reset interferes.
- R7: Kicks that arrive while `rst_req` is high neither shorten nor extend the request.
- R8: When a request ends, counting restarts from zero, so the next request follows TIMEOUT_CYC cycles later.
- R9: An external reset is asserted when `ext_rst_lvl` is 1 or `ext_rst_n_lvl` is 0, in any state. It drops `rst_req` on the next cycle and holds the counter. Counting resumes on the first edge at which at least PULSE_CYC cycles have passed since the assertion and the pin is released.
- R10: `timing_out` is high for exactly one cycle: the first cycle of each timeout-driven request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| supply_ok | input | 1 | Supply above trip level; low value holds and asynchronously clears the block |
| kick | input | 1 | One-cycle pulse when the serial slave acknowledges |
| ext_rst_lvl | input | 1 | Synchronised level of the active-high external reset pin |
| ext_rst_n_lvl | input | 1 | Synchronised level of the active-low external reset pin |
| rst_req | output | 1 | Request to drive both reset outputs |
| timing_out | output | 1 | One-cycle strobe marking the first cycle of a timeout request |

## Verification
A kick and the terminal count can land in the same cycle. The bench provokes this by pulsing `kick` on exactly the TIMEOUT_CYC-th edge after an earlier kick. It judges the outcome by checking that `rst_req` stays low and that the next request arrives a full TIMEOUT_CYC edges after that late kick. A kick can also coincide with a request already in progress. The bench drives kicks during the pulse and confirms that the pulse still ends exactly PULSE_CYC cycles after it began.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    WD_HOLD = 2'd0,
    WD_RUN  = 2'd1,
    WD_BITE = 2'd2
  } wd_state_e;

  // counter width able to hold values 0 .. n-1
  function automatic int unsigned width_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // either external reset pin asserted
  function automatic logic ext_asserted(input logic hi_lvl, input logic lo_n_lvl);
    return hi_lvl | ~lo_n_lvl;
  endfunction

endpackage

// File: rtl/wdt_span_timer.sv
module wdt_span_timer #(
  parameter int unsigned LEN = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic done
);
  import wdt_pkg::*;

  localparam int unsigned W = width_for(LEN);
  localparam logic [W-1:0] LAST = W'(LEN - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (en && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LAST);

endmodule

// File: rtl/wdt_run_counter.sv
module wdt_run_counter #(
  parameter int unsigned TIMEOUT_CYC = 1600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic kick,
  output logic terminal
);
  import wdt_pkg::*;

  localparam int unsigned W = width_for(TIMEOUT_CYC);
  localparam logic [W-1:0] LAST = W'(TIMEOUT_CYC - 1);

  logic [W-1:0] cnt;

  assign terminal = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (!run || kick || terminal) cnt <= '0;
    else                               cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ext,
  input  logic                kick,
  input  logic                terminal,
  input  logic                span_done,
  output wdt_pkg::wd_state_e  state,
  output logic                span_clr,
  output logic                bite_start
);
  import wdt_pkg::*;

  wd_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      WD_HOLD: if (span_done && !ext) nxt = WD_RUN;
      WD_RUN: begin
        if (ext)                   nxt = WD_HOLD;
        else if (terminal && !kick) nxt = WD_BITE;
      end
      WD_BITE: begin
        if (ext)            nxt = WD_HOLD;
        else if (span_done) nxt = WD_RUN;
      end
      default: nxt = WD_HOLD;
    endcase
  end

  assign span_clr   = (nxt != state) && (nxt != WD_RUN);
  assign bite_start = (state == WD_RUN) && (nxt == WD_BITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= WD_HOLD;
    else        state <= nxt;
  end

endmodule

// File: rtl/ack_watchdog.sv
module ack_watchdog #(
  parameter int unsigned TIMEOUT_CYC = 1600,
  parameter int unsigned PULSE_CYC   = 200
) (
  input  logic clk,
  input  logic supply_ok,
  input  logic kick,
  input  logic ext_rst_lvl,
  input  logic ext_rst_n_lvl,
  output logic rst_req,
  output logic timing_out
);
  import wdt_pkg::*;

  // named internal events, visible to the bound checker
  wd_state_e state;
  logic      ext_any;
  logic      run_terminal;
  logic      span_done;
  logic      span_clr;
  logic      bite_start;
  logic      tout_q;

  assign ext_any = ext_asserted(ext_rst_lvl, ext_rst_n_lvl);

  wdt_run_counter #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_run (
    .clk      (clk),
    .rst_n    (supply_ok),
    .run      (state == WD_RUN),
    .kick     (kick),
    .terminal (run_terminal)
  );

  wdt_span_timer #(.LEN(PULSE_CYC)) u_span (
    .clk   (clk),
    .rst_n (supply_ok),
    .clr   (span_clr),
    .en    (state != WD_RUN),
    .done  (span_done)
  );

  wdt_fsm u_fsm (
    .clk        (clk),
    .rst_n      (supply_ok),
    .ext        (ext_any),
    .kick       (kick),
    .terminal   (run_terminal),
    .span_done  (span_done),
    .state      (state),
    .span_clr   (span_clr),
    .bite_start (bite_start)
  );

  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok) tout_q <= 1'b0;
    else            tout_q <= bite_start;
  end

  assign rst_req    = (state == WD_BITE);
  assign timing_out = tout_q;

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int unsigned TIMEOUT_CYC = 1600,
  parameter int unsigned PULSE_CYC   = 200
) (
  input logic clk,
  input logic supply_ok,
  input logic kick,
  input logic ext_any,
  input logic run_terminal,
  input logic rst_req,
  input logic timing_out
);
  localparam int unsigned WW = $clog2(PULSE_CYC + 2);

  logic [WW-1:0] wcnt;

  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok)   wcnt <= '0;
    else if (rst_req) wcnt <= wcnt + 1'b1;
    else              wcnt <= '0;
  end

  always @(negedge clk) begin
    if (!supply_ok) begin
      assert_quiet_in_reset_R1: assert (!rst_req && !timing_out);
    end
  end

  assert_timeout_bites_R3: assert property (@(posedge clk) disable iff (!supply_ok)
    (run_terminal && !kick && !ext_any) |=> rst_req);

  assert_kick_beats_terminal_R5: assert property (@(posedge clk) disable iff (!supply_ok)
    (run_terminal && kick && !ext_any) |=> !rst_req);

  assert_pulse_not_long_R6: assert property (@(posedge clk) disable iff (!supply_ok)
    int'(wcnt) <= int'(PULSE_CYC));

  assert_pulse_exact_R6: assert property (@(posedge clk) disable iff (!supply_ok)
    (!rst_req && wcnt != '0 && !$past(ext_any)) |-> int'(wcnt) == int'(PULSE_CYC));

  assert_ext_drops_request_R9: assert property (@(posedge clk) disable iff (!supply_ok)
    ext_any |=> !rst_req);

  assert_strobe_on_rise_R10: assert property (@(posedge clk) disable iff (!supply_ok)
    $rose(rst_req) |-> timing_out);

  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!supply_ok)
    timing_out |=> !timing_out);

endmodule

bind ack_watchdog wdt_checker #(
  .TIMEOUT_CYC (TIMEOUT_CYC),
  .PULSE_CYC   (PULSE_CYC)
) u_chk (
  .clk          (clk),
  .supply_ok    (supply_ok),
  .kick         (kick),
  .ext_any      (ext_any),
  .run_terminal (run_terminal),
  .rst_req      (rst_req),
  .timing_out   (timing_out)
);

// File: tb/tb_ack_watchdog.sv
module tb_ack_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int TO = 20;
  localparam int PL = 6;

  logic clk = 1'b0;
  logic supply_ok = 1'b0;
  logic kick = 1'b0;
  logic ext_hi = 1'b0;
  logic ext_lo_n = 1'b1;
  logic rst_req, timing_out;

  int nchk = 0;
  int nfail = 0;
  int g = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ack_watchdog #(.TIMEOUT_CYC(TO), .PULSE_CYC(PL)) dut (
    .clk           (clk),
    .supply_ok     (supply_ok),
    .kick          (kick),
    .ext_rst_lvl   (ext_hi),
    .ext_rst_n_lvl (ext_lo_n),
    .rst_req       (rst_req),
    .timing_out    (timing_out)
  );

  // gap after a kick (edges), expected rst_req
  localparam int NV = 8;
  localparam int VGAP [NV] = '{3, 12, 18, 19, 20, 23, 25, 26};
  localparam bit VEXP [NV] = '{0, 0, 0, 0, 1, 1, 1, 0};

  task automatic chk(input string tag, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0b expected %0b (gap %0d)", tag, act, exp, g);
    end
  endtask

  // one clock edge with optional kick; returns at the following falling edge
  task automatic step(input logic k);
    kick = k;
    @(posedge clk);
    @(negedge clk);
    kick = 1'b0;
    g++;
  endtask

  task automatic goto_gap(input int t);
    while (g < t) step(1'b0);
  endtask

  // leave any request, then kick so that g counts edges from that kick
  task automatic fresh();
    int guard;
    guard = 0;
    while (rst_req && guard < 100) begin
      step(1'b0);
      guard++;
    end
    step(1'b1);
    g = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: supply low, kicks present
    step(1'b1);
    step(1'b0);
    chk("R1 reset rst_req", rst_req, 1'b0);
    chk("R1 reset timing_out", timing_out, 1'b0);

    // R2: power-up hold, kicks during hold ignored
    supply_ok = 1'b1;
    g = 0;
    step(1'b1);
    step(1'b1);
    step(1'b0);
    goto_gap(PL + TO - 1);
    chk("R2 before first request", rst_req, 1'b0);
    step(1'b0);
    chk("R2 first request", rst_req, 1'b1);
    chk("R10 strobe on first cycle", timing_out, 1'b1);
    step(1'b0);
    chk("R10 strobe gone", timing_out, 1'b0);

    // R3 R4: vector table
    for (int i = 0; i < NV; i++) begin
      fresh();
      goto_gap(VGAP[i]);
      chk("R3 R4 vector", rst_req, VEXP[i]);
    end

    // R5: kick exactly on terminal count
    fresh();
    goto_gap(TO - 1);
    step(1'b1);
    g = 0;
    chk("R5 kick on terminal", rst_req, 1'b0);
    goto_gap(TO - 1);
    chk("R4 restart after late kick", rst_req, 1'b0);
    step(1'b0);
    chk("R3 request after late kick", rst_req, 1'b1);

    // R7 R6: kicks during the request
    step(1'b1);
    step(1'b1);
    step(1'b1);
    goto_gap(TO + PL - 1);
    chk("R7 request not shortened", rst_req, 1'b1);
    step(1'b0);
    chk("R6 request ends after pulse", rst_req, 1'b0);

    // R8: restart after the request
    goto_gap(2 * TO + PL - 1);
    chk("R8 before second request", rst_req, 1'b0);
    step(1'b0);
    chk("R8 second request", rst_req, 1'b1);

    // R9: short active-low external reset
    fresh();
    ext_lo_n = 1'b0;
    step(1'b0);
    step(1'b0);
    ext_lo_n = 1'b1;
    goto_gap(PL + TO);
    chk("R9 short ext hold", rst_req, 1'b0);
    step(1'b0);
    chk("R9 short ext then request", rst_req, 1'b1);

    // R9: long active-high external reset
    fresh();
    ext_hi = 1'b1;
    repeat (15) step(1'b0);
    ext_hi = 1'b0;
    goto_gap(15 + TO);
    chk("R9 long ext hold", rst_req, 1'b0);
    step(1'b0);
    chk("R9 long ext then request", rst_req, 1'b1);

    // R9: external reset during a request
    fresh();
    goto_gap(TO + 1);
    chk("R9 request before ext", rst_req, 1'b1);
    ext_hi = 1'b1;
    step(1'b0);
    chk("R9 ext ends request", rst_req, 1'b0);
    ext_hi = 1'b0;

    // R1: supply drop during a request
    fresh();
    goto_gap(TO + 2);
    supply_ok = 1'b0;
    #1;
    chk("R1 supply drop clears request", rst_req, 1'b0);
    chk("R1 supply drop clears strobe", timing_out, 1'b0);
    step(1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule